// File: doc/BRIEF.md
# VCO Sub-Band Calibration Controller with Lock Supervision

This controller picks the sub-band of a multi-band VCO. It runs on the reference clock. For each trial it applies a band code to the oscillator and counts oscillator edges over a fixed gate of reference cycles. It then compares that count with a target count. The search is binary, starting from the most significant bit. A final step measures the chosen code and the code above it, and keeps whichever count lies nearer the target. While the search runs, `loop_open` asks the analog loop to hold its control voltages at their common-mode value.

After a search ends, a fixed hold interval gives the loop time to settle into lock. The controller then arms a supervisor on four window comparators that watch the two differential control lines. If any comparator reports its line outside the linear window for two reference cycles in a row, the controller starts the complete search again. It never nudges the band code up or down by one. A start pulse restarts the search in any state.

Top module: `afc_cal_top`

## Requirements
- R1: While reset is asserted and after it is released with no start, `band_code` is 0 and `busy`, `loop_open` and `done` are all 0.
- R2: One cycle after `start` is sampled high, `busy` and `loop_open` are both 1, whatever state the controller was in.
- R3: When a search ends, `band_code` holds the code whose measured edge count is closest to `target_cnt`. The measured count rises with the code.
- R4: A target below the count of code 0 gives code 0. A target above the count of code 255 gives code 255.
- R5: A search ends within (BAND_W+2)*(SETTLE_CYC+GATE_CYC+DRAIN_CYC)+2 cycles. At that point `busy` and `loop_open` fall and `done` rises, and `band_code` then stays fixed until the next search.
- R6: For HOLD_CYC cycles after a search ends, the comparator flags are ignored. `busy` stays 0 and `band_code` is unchanged even when a flag is 0.
- R7: Once armed, a comparator flag that is 0 for only a single reference cycle causes no recalibration.
- R8: Once armed, any comparator flag held at 0 for two or more cycles starts a full new search. A flag of 1 means the line is inside the window, and 0 means it is outside. The new search begins from trial code 0x80 with `busy` at 1, and it ends with the code that is nearest the target again.
- R9: A start pulse during a search abandons that search. The result then reflects only the newest target.
- R10: A start pulse while the supervisor is armed launches a new search for the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all control logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run a calibration |
| target_cnt | input | CNT_W | Wanted oscillator edge count per gate |
| vco_clk | input | 1 | Oscillator clock (or divided oscillator clock) to be counted |
| ok_flags | input | N_FLAG | Window comparator outputs, 1 = control line inside window |
| band_code | output | BAND_W | Sub-band select for the oscillator |
| loop_open | output | 1 | Hold the control voltages at common mode |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, hold or supervision active |

## Verification
The bench aims at the edges of the code range. Targets beyond either end must saturate at 0 or 255. A design that mishandled the neighbour step at the top code would wrap to 0. The bench also covers the count jitter of one edge at an exact target. Without the final neighbour comparison, the search would settle one code low.

The bench drops comparator flags during the hold interval, pulses a flag for a single cycle, and holds it low for several cycles. A supervisor armed too early, or one without the two-cycle filter, would start spurious searches. A supervisor that stepped the code would not show the 0x80 trial. A start pulse in the middle of a search checks that a stale result is never reported.

// File: rtl/afc_pkg.sv
`timescale 1ns/1ps
package afc_pkg;
    typedef enum logic [1:0] {
        M_IDLE,
        M_CAL,
        M_SETTLE,
        M_MON
    } mode_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETTLE,
        PH_GATE,
        PH_DRAIN
    } phase_t;
endpackage

// File: rtl/afc_edge_counter.sv
`timescale 1ns/1ps
// Counts oscillator edges in the oscillator domain while a resynchronised gate is high.
module afc_edge_counter #(
    parameter int CNT_W = 16
) (
    input  logic             vco_clk,
    input  logic             rst_n,
    input  logic             gate,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [2:0]       g;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.g = {st_q.g[1:0], gate};
        if (st_q.g[1] && !st_q.g[2]) begin
            st_d.cnt = CNT_W'(1);
        end else if (st_q.g[1]) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // Count is frozen once the gate has left the synchroniser (R3 relies on a stable read).
    p_frozen_r3: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (!st_q.g[1] && !st_q.g[2]) |=> (count == $past(count)));
endmodule

// File: rtl/afc_lock_watch.sv
`timescale 1ns/1ps
// Synchronises the window comparator flags and asks for a restart when any flag is low for two cycles.
module afc_lock_watch #(
    parameter int N_FLAG = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FLAG-1:0] ok_flags,
    input  logic              arm,
    output logic              restart
);
    typedef struct packed {
        logic [N_FLAG-1:0] s1;
        logic [N_FLAG-1:0] s2;
        logic              hi;
    } watch_st_t;

    watch_st_t st_d, st_q;
    logic      out_of_win;

    always_comb begin
        out_of_win = ~&st_q.s2;
        st_d       = st_q;
        st_d.s1    = ok_flags;
        st_d.s2    = st_q.s1;
        st_d.hi    = arm && out_of_win;
        restart    = arm && out_of_win && st_q.hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: '1, s2: '1, hi: 1'b0};
        else        st_q <= st_d;
    end

    // A restart needs the input flags out of window on two successive samples.
    p_persist_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> ($past(~&ok_flags, 2) && $past(~&ok_flags, 3)));
endmodule

// File: rtl/afc_search.sv
`timescale 1ns/1ps
// Binary search of the band code, MSB first, followed by a neighbour comparison.
module afc_search
    import afc_pkg::*;
#(
    parameter int BAND_W     = 8,
    parameter int CNT_W      = 16,
    parameter int SETTLE_CYC = 2,
    parameter int GATE_CYC   = 12,
    parameter int DRAIN_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CNT_W-1:0]  target,
    input  logic [CNT_W-1:0]  meas,
    output logic [BAND_W-1:0] band,
    output logic              gate,
    output logic              active,
    output logic              finish
);
    localparam int TMR_W  = $clog2(SETTLE_CYC + GATE_CYC + DRAIN_CYC + 1);
    localparam int STEP_W = $clog2(BAND_W + 2);
    localparam logic [STEP_W-1:0] STEP_LO = STEP_W'(BAND_W);
    localparam logic [BAND_W-1:0] MID_CODE = BAND_W'(1) << (BAND_W - 1);

    typedef struct packed {
        phase_t            ph;
        logic [STEP_W-1:0] step;
        logic [BAND_W-1:0] code;
        logic [BAND_W-1:0] trial;
        logic [TMR_W-1:0]  tmr;
        logic [CNT_W-1:0]  lo_cnt;
        logic              fin;
    } srch_st_t;

    srch_st_t st_d, st_q;

    function automatic logic [CNT_W-1:0] absdiff(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    always_comb begin
        int bi;
        logic [BAND_W-1:0] kept;
        bi       = BAND_W - 1 - int'(st_q.step);
        kept     = '0;
        st_d     = st_q;
        st_d.fin = 1'b0;
        if (go) begin
            st_d.ph    = PH_SETTLE;
            st_d.step  = '0;
            st_d.code  = '0;
            st_d.trial = MID_CODE;
            st_d.tmr   = '0;
        end else begin
            case (st_q.ph)
                PH_SETTLE: begin
                    st_d.tmr = st_q.tmr + 1'b1;
                    if (st_q.tmr == TMR_W'(SETTLE_CYC - 1)) begin
                        st_d.ph  = PH_GATE;
                        st_d.tmr = '0;
                    end
                end
                PH_GATE: begin
                    st_d.tmr = st_q.tmr + 1'b1;
                    if (st_q.tmr == TMR_W'(GATE_CYC - 1)) begin
                        st_d.ph  = PH_DRAIN;
                        st_d.tmr = '0;
                    end
                end
                PH_DRAIN: begin
                    st_d.tmr = st_q.tmr + 1'b1;
                    if (st_q.tmr == TMR_W'(DRAIN_CYC - 1)) begin
                        st_d.tmr  = '0;
                        st_d.ph   = PH_SETTLE;
                        st_d.step = st_q.step + 1'b1;
                        if (st_q.step < STEP_LO) begin
                            kept = (meas <= target) ? st_q.trial
                                                    : (st_q.trial & ~(BAND_W'(1) << bi));
                            st_d.code  = kept;
                            st_d.trial = (bi == 0) ? kept : (kept | (BAND_W'(1) << (bi - 1)));
                        end else if (st_q.step == STEP_LO) begin
                            st_d.lo_cnt = meas;
                            if (&st_q.code) begin
                                st_d.ph  = PH_IDLE;
                                st_d.fin = 1'b1;
                            end else begin
                                st_d.trial = st_q.code + 1'b1;
                            end
                        end else begin
                            if (absdiff(meas, target) < absdiff(st_q.lo_cnt, target)) begin
                                st_d.code = st_q.trial;
                            end
                            st_d.ph  = PH_IDLE;
                            st_d.fin = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign active = (st_q.ph != PH_IDLE);
    assign band   = active ? st_q.trial : st_q.code;
    assign gate   = (st_q.ph == PH_GATE);
    assign finish = st_q.fin;

    p_first_trial_r8: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (active && band == MID_CODE));
    p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !go) |=> $stable(band));
endmodule

// File: rtl/afc_cal_top.sv
`timescale 1ns/1ps
// Top: calibration mode sequencing, settle hold and armed lock supervision.
module afc_cal_top
    import afc_pkg::*;
#(
    parameter int BAND_W     = 8,
    parameter int CNT_W      = 16,
    parameter int N_FLAG     = 4,
    parameter int SETTLE_CYC = 2,
    parameter int GATE_CYC   = 12,
    parameter int DRAIN_CYC  = 2,
    parameter int HOLD_CYC   = 2000
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  target_cnt,
    input  logic              vco_clk,
    input  logic [N_FLAG-1:0] ok_flags,
    output logic [BAND_W-1:0] band_code,
    output logic              loop_open,
    output logic              busy,
    output logic              done
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        mode_t             mode;
        logic [HOLD_W-1:0] hold;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             restart, go, arm, gate, s_active, s_fin;
    logic [CNT_W-1:0] meas;

    afc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .vco_clk (vco_clk),
        .rst_n   (rst_n),
        .gate    (gate),
        .count   (meas)
    );

    afc_search #(
        .BAND_W     (BAND_W),
        .CNT_W      (CNT_W),
        .SETTLE_CYC (SETTLE_CYC),
        .GATE_CYC   (GATE_CYC),
        .DRAIN_CYC  (DRAIN_CYC)
    ) u_srch (
        .clk    (ref_clk),
        .rst_n  (rst_n),
        .go     (go),
        .target (target_cnt),
        .meas   (meas),
        .band   (band_code),
        .gate   (gate),
        .active (s_active),
        .finish (s_fin)
    );

    afc_lock_watch #(.N_FLAG(N_FLAG)) u_watch (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .ok_flags (ok_flags),
        .arm      (arm),
        .restart  (restart)
    );

    always_comb begin
        arm  = (st_q.mode == M_MON);
        go   = start || restart;
        st_d = st_q;
        if (go) begin
            st_d.mode = M_CAL;
        end else begin
            case (st_q.mode)
                M_CAL: if (s_fin) begin
                    st_d.mode = M_SETTLE;
                    st_d.hold = '0;
                end
                M_SETTLE: begin
                    st_d.hold = st_q.hold + 1'b1;
                    if (st_q.hold == HOLD_W'(HOLD_CYC - 1)) st_d.mode = M_MON;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: M_IDLE, hold: '0};
        else        st_q <= st_d;
    end

    assign busy      = (st_q.mode == M_CAL);
    assign loop_open = busy;
    assign done      = (st_q.mode == M_SETTLE) || (st_q.mode == M_MON);

    p_launch_r2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        start |=> (busy && loop_open));
    p_excl_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(busy && done));
    p_hold_quiet_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (st_q.mode == M_SETTLE && !start) |=> !busy);
    p_full_rerun_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (arm && restart) |=> (busy && s_active));
endmodule

// File: tb/sim_afc_cal_top.sv
`timescale 1ns/1ps
module sim_afc_cal_top;
    localparam int BW = 8, CW = 16, NF = 4;
    localparam int SC = 4, GC = 200, DC = 12, HC = 2000;
    localparam int BUSY_MAX = (BW + 2) * (SC + GC + DC) + 2;

    logic          ref_clk = 1'b0, vco_clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [CW-1:0] target = '0;
    logic [NF-1:0] okf = '1;
    logic [BW-1:0] band_code;
    logic          loop_open, busy, done;

    typedef struct {
        int    band;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    int   n_chk = 0, n_fail = 0;

    afc_cal_top #(
        .BAND_W(BW), .CNT_W(CW), .N_FLAG(NF), .SETTLE_CYC(SC),
        .GATE_CYC(GC), .DRAIN_CYC(DC), .HOLD_CYC(HC)
    ) u0 (
        .ref_clk(ref_clk), .rst_n(rst_n), .start(start), .target_cnt(target),
        .vco_clk(vco_clk), .ok_flags(okf), .band_code(band_code),
        .loop_open(loop_open), .busy(busy), .done(done)
    );

    always #2 ref_clk = ~ref_clk;

    // Oscillator model: half period in ps falls as the band code rises.
    function automatic int hp_ps(int b);
        return 100000 / (b + 16);
    endfunction
    function automatic int model_cnt(int b);
        return (GC * 4000) / (2 * hp_ps(b));
    endfunction
    function automatic int exp_band(int t);
        int best = 0, bd, d;
        bd = (model_cnt(0) > t) ? model_cnt(0) - t : t - model_cnt(0);
        for (int b = 1; b < (1 << BW); b++) begin
            d = (model_cnt(b) > t) ? model_cnt(b) - t : t - model_cnt(b);
            if (d < bd) begin bd = d; best = b; end
        end
        return best;
    endfunction

    always begin
        #(real'(hp_ps(int'(band_code))) / 1000.0) vco_clk = ~vco_clk;
    end

    task automatic chk(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    task automatic launch(int t, string tag, bit replace);
        exp_t e;
        @(negedge ref_clk);
        target = CW'(t);
        start  = 1'b1;
        if (replace && exp_q.size() > 0) void'(exp_q.pop_back());
        e.band = exp_band(t);
        e.tag  = tag;
        exp_q.push_back(e);
        @(negedge ref_clk);
        start = 1'b0;
        chk(busy && loop_open, "R2", {busy, loop_open}, 3);
    endtask

    task automatic wait_done();
        int n = 0;
        while (exp_q.size() != 0 && n < 4 * BUSY_MAX) begin
            @(negedge ref_clk);
            n++;
        end
        chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
    endtask

    // Scoreboard monitor: compares each finished search with the oldest expectation.
    int busy_len = 0;
    logic busy_prev = 1'b0;
    always @(negedge ref_clk) begin
        exp_t e;
        if (start || (busy && !busy_prev)) busy_len = 0;
        if (busy) busy_len++;
        if (busy_prev && !busy) begin
            chk(busy_len <= BUSY_MAX, "R5", busy_len, BUSY_MAX);
            chk(done && !loop_open, "R5", {done, loop_open}, 2);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", int'(band_code), -1);
            end else begin
                e = exp_q.pop_front();
                chk(int'(band_code) == e.band, e.tag, int'(band_code), e.band);
            end
        end
        busy_prev = busy;
    end

    initial begin
        repeat (150000) @(posedge ref_clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int held;
        bit seen;
        int first_band;
        repeat (3) @(negedge ref_clk);
        chk(band_code == '0 && !busy && !loop_open && !done, "R1", int'(band_code), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge ref_clk);
        chk(band_code == '0 && !busy && !loop_open && !done, "R1", {busy, loop_open, done}, 0);

        launch(model_cnt(8'h5A), "R3", 1'b0);
        wait_done();

        // R6: flags out of window during the hold interval are ignored
        held = int'(band_code);
        okf = 4'b1011;
        for (int i = 0; i < 30; i++) begin
            @(negedge ref_clk);
            if (busy || int'(band_code) != held) chk(1'b0, "R6", int'(band_code), held);
        end
        chk(!busy && done && int'(band_code) == held, "R6", int'(band_code), held);
        okf = '1;
        repeat (HC + 20) @(negedge ref_clk);

        // R7: a single-cycle glitch once armed
        okf = 4'b1110;
        @(negedge ref_clk);
        okf = '1;
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge ref_clk);
            if (busy) seen = 1'b1;
        end
        chk(!seen && done, "R7", seen, 0);

        // R8: sustained out-of-window flag triggers a complete new search
        begin
            exp_t e;
            e.band = exp_band(model_cnt(8'h5A));
            e.tag  = "R8";
            exp_q.push_back(e);
        end
        okf = 4'b0111;
        seen = 1'b0;
        first_band = -1;
        for (int i = 0; i < 10 && !seen; i++) begin
            @(negedge ref_clk);
            if (busy) begin
                seen = 1'b1;
                first_band = int'(band_code);
            end
        end
        okf = '1;
        chk(seen, "R8", seen, 1);
        chk(first_band == 8'h80, "R8", first_band, 8'h80);
        wait_done();

        // R10: start while supervision is armed
        repeat (HC + 20) @(negedge ref_clk);
        launch(model_cnt(8'h80), "R10", 1'b0);
        wait_done();

        launch(model_cnt(8'h7F), "R3", 1'b0);
        wait_done();
        launch(model_cnt(8'h01), "R3", 1'b0);
        wait_done();
        launch(model_cnt(8'hFE), "R3", 1'b0);
        wait_done();
        launch(10, "R4", 1'b0);
        wait_done();
        launch(4000, "R4", 1'b0);
        wait_done();

        // R9: restart in the middle of a search
        launch(model_cnt(8'h20), "R9", 1'b0);
        repeat (400) @(negedge ref_clk);
        launch(model_cnt(8'hC3), "R9", 1'b1);
        wait_done();

        repeat (5) @(negedge ref_clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule